// File: doc/BRIEF.md
# Single-Cell Lithium Charge Sequencer

This block is the phase controller of a linear charger for one lithium cell. It does not measure anything itself. The analog front end supplies a set of comparison flags: battery voltage above each decision level, sense current above the end-of-charge level, cell present and supply present. It also supplies a slow time-base tick. From these the block decides which regulation loop drives the pass device and what the two status LEDs show.

A normal charge runs through four steps. A deeply discharged cell is first woken with a reduced current. It then charges at full constant current until it reaches the full voltage. It then holds constant voltage until the current tapers off. Once finished, it waits and restarts the charge if the cell sags. Two health checks can be switched on. The first probes a nearly dead cell with a train of voltage pulses before any charging starts. The second leaves a freshly terminated cell idle for a chosen time and then checks that its voltage has not drooped. A failed check, or a trickle phase that runs too long, latches a fault. Only removing the cell, or a reset, clears it.

All durations are counted in ticks of `tick`, nominally 1 Hz, and are set by parameters. Every output is decoded from the registered phase, so each output is free of glitches relative to the clock.

Top module: `chg_seq`

## Requirements
- R1: After reset the block is idle and all six outputs (`cc_en`, `cv_en`, `trickle_sel`, `pulse_drive`, `led0`, `led1`) are 0.
- R2: From idle, with `bat_present` and `supply_ok` both high, the block starts as follows:
  - If `precheck_en` is high and `v_above_dead` is low, it enters the pulse probe.
  - Otherwise, if `v_above_trickle` is low, it enters trickle, with `cc_en=1` and `trickle_sel=1`.
  - Otherwise it enters constant current, with `cc_en=1` and `trickle_sel=0`.
- R3: In trickle, `v_above_trickle` high moves the block to constant current one edge later.
- R4: If TRICKLE_TICKS ticks pass in trickle without `v_above_trickle`, the block enters fault on the edge of that last tick.
- R5: In constant current, `v_above_full` high moves the block to constant voltage (`cv_en=1`, `cc_en=0`).
- R6: In constant voltage, `i_above_term` low ends the charge. With `idlechk_en` low, the block goes to done (`led1=1`, all regulation off).
- R7: In done, `v_above_recharge` low restarts constant current.
- R8: `bat_present` low returns the block to idle from any phase, including fault. `supply_ok` low returns it to idle from any phase except fault.
- R9: Fault turns off all regulation. It is left only through `bat_present` low or reset. Both LEDs are on in the first fault cycle and both toggle on each tick.
- R10: The pulse probe runs PULSE_COUNT pulses. Each pulse holds `pulse_drive` high for PULSE_HI ticks and then low for PULSE_LO ticks. `v_above_dead` is sampled only on the last tick of the last pulse: if it is low the block enters fault; if it is high the block goes to trickle or constant current according to `v_above_trickle`.
- R11: With `idlechk_en` high, ending constant voltage starts an idle check. The check lasts IDLE_SHORT ticks (`idle_long` = 0) or IDLE_LONG ticks (`idle_long` = 1). On its last tick, `v_above_droop` high leads to done and low leads to fault. `v_above_recharge` is ignored during the check.
- R12: `cc_en` and `cv_en` are never high together, and `trickle_sel` is high only when `cc_en` is high.
- R13: The LEDs show the phase:
  - `led0` is on in pulse probe, trickle, constant current and constant voltage.
  - `led1` is on in done and in the idle check.
  - Both are off in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle time-base pulse (nominally 1 Hz) |
| bat_present | input | 1 | Cell is connected |
| supply_ok | input | 1 | Input supply is present |
| v_above_dead | input | 1 | Cell above the dead-cell level (2.5 V) |
| v_above_trickle | input | 1 | Cell at or above the trickle exit level (3.0 V) |
| v_above_full | input | 1 | Cell at the selected full voltage |
| v_above_recharge | input | 1 | Cell above full minus 0.1 V |
| v_above_droop | input | 1 | Cell above the idle-droop limit |
| i_above_term | input | 1 | Charge current above the end-of-charge level |
| precheck_en | input | 1 | Enable the pulse probe |
| idlechk_en | input | 1 | Enable the idle droop check |
| idle_long | input | 1 | Select the longer idle-check duration |
| cc_en | output | 1 | Constant-current regulation select |
| cv_en | output | 1 | Constant-voltage regulation select |
| trickle_sel | output | 1 | Reduced (trickle) current select |
| pulse_drive | output | 1 | Pulse-probe voltage drive enable |
| led0 | output | 1 | Charging indicator |
| led1 | output | 1 | Done indicator |

## Verification
Every output changes on the first clock edge after the input that causes it. Level flags take effect on the edge that samples them. Timed decisions take effect on the edge that samples the deciding tick.

The bench drives all inputs on the falling edge. It samples one falling edge later, so each check sees exactly one registered update. Duration checks count ticks and confirm the phase both one tick before its limit and at the limit.

Random flag sequences through constant current, constant voltage and done are compared against a phase model in the bench, with random ticks applied to show that those phases ignore time.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_PRECHECK = 3'd1,
    ST_TRICKLE  = 3'd2,
    ST_CC       = 3'd3,
    ST_CV       = 3'd4,
    ST_DONE     = 3'd5,
    ST_IDLECHK  = 3'd6,
    ST_FAULT    = 3'd7
  } chg_state_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/chg_span_cnt.sv
module chg_span_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/chg_ctrl.sv
module chg_ctrl
  import chg_pkg::*;
#(
  parameter int TRICKLE_TICKS = 1800,
  parameter int PULSE_HI      = 10,
  parameter int PULSE_LO      = 5,
  parameter int PULSE_COUNT   = 15,
  parameter int IDLE_SHORT    = 600,
  parameter int IDLE_LONG     = 900,
  parameter int CW            = 11,
  parameter int PW            = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bat_present,
  input  logic          supply_ok,
  input  logic          v_above_dead,
  input  logic          v_above_trickle,
  input  logic          v_above_full,
  input  logic          v_above_recharge,
  input  logic          v_above_droop,
  input  logic          i_above_term,
  input  logic          precheck_en,
  input  logic          idlechk_en,
  input  logic          idle_long,
  input  logic [CW-1:0] span,
  input  logic [PW-1:0] pulses,
  output chg_state_t    st,
  output logic          span_clr,
  output logic          span_step,
  output logic          pulse_clr,
  output logic          pulse_step
);
  localparam int PERIOD = PULSE_HI + PULSE_LO;
  localparam logic [CW-1:0] TRK_LAST = CW'(TRICKLE_TICKS - 1);
  localparam logic [CW-1:0] PER_LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] IS_LAST  = CW'(IDLE_SHORT - 1);
  localparam logic [CW-1:0] IL_LAST  = CW'(IDLE_LONG - 1);
  localparam logic [PW-1:0] PC_LAST  = PW'(PULSE_COUNT - 1);

  chg_state_t nxt;
  logic       wrap;
  logic [CW-1:0] idle_last;

  assign wrap      = (st == ST_PRECHECK) && tick && (span == PER_LAST);
  assign idle_last = idle_long ? IL_LAST : IS_LAST;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE: begin
        if (bat_present && supply_ok) begin
          if (precheck_en && !v_above_dead) nxt = ST_PRECHECK;
          else if (!v_above_trickle)        nxt = ST_TRICKLE;
          else                              nxt = ST_CC;
        end
      end
      ST_PRECHECK: begin
        if (wrap && (pulses == PC_LAST)) begin
          if (!v_above_dead)        nxt = ST_FAULT;
          else if (v_above_trickle) nxt = ST_CC;
          else                      nxt = ST_TRICKLE;
        end
      end
      ST_TRICKLE: begin
        if (v_above_trickle)                  nxt = ST_CC;
        else if (tick && (span == TRK_LAST))  nxt = ST_FAULT;
      end
      ST_CC:   if (v_above_full) nxt = ST_CV;
      ST_CV:   if (!i_above_term) nxt = idlechk_en ? ST_IDLECHK : ST_DONE;
      ST_DONE: if (!v_above_recharge) nxt = ST_CC;
      ST_IDLECHK: begin
        if (tick && (span == idle_last)) nxt = v_above_droop ? ST_DONE : ST_FAULT;
      end
      ST_FAULT: nxt = ST_FAULT;
      default:  nxt = ST_IDLE;
    endcase
    if (!bat_present)                        nxt = ST_IDLE;
    else if (!supply_ok && st != ST_FAULT)   nxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  assign span_clr   = (nxt != st) || wrap;
  assign span_step  = tick && ((st == ST_PRECHECK) || (st == ST_TRICKLE) || (st == ST_IDLECHK));
  assign pulse_clr  = (st != ST_PRECHECK);
  assign pulse_step = wrap;
endmodule

// File: rtl/chg_led.sv
module chg_led
  import chg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  chg_state_t st,
  output logic       led0,
  output logic       led1
);
  logic blink;
  logic charging;
  logic finished;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               blink <= 1'b1;
    else if (st != ST_FAULT)  blink <= 1'b1;
    else if (tick)            blink <= ~blink;
  end

  assign charging = (st == ST_PRECHECK) || (st == ST_TRICKLE) || (st == ST_CC) || (st == ST_CV);
  assign finished = (st == ST_DONE) || (st == ST_IDLECHK);

  assign led0 = (st == ST_FAULT) ? blink : charging;
  assign led1 = (st == ST_FAULT) ? blink : finished;
endmodule

// File: rtl/chg_seq.sv
module chg_seq
  import chg_pkg::*;
#(
  parameter int TRICKLE_TICKS = 1800,
  parameter int PULSE_HI      = 10,
  parameter int PULSE_LO      = 5,
  parameter int PULSE_COUNT   = 15,
  parameter int IDLE_SHORT    = 600,
  parameter int IDLE_LONG     = 900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic bat_present,
  input  logic supply_ok,
  input  logic v_above_dead,
  input  logic v_above_trickle,
  input  logic v_above_full,
  input  logic v_above_recharge,
  input  logic v_above_droop,
  input  logic i_above_term,
  input  logic precheck_en,
  input  logic idlechk_en,
  input  logic idle_long,
  output logic cc_en,
  output logic cv_en,
  output logic trickle_sel,
  output logic pulse_drive,
  output logic led0,
  output logic led1
);
  localparam int SPAN_MAX = max2(max2(TRICKLE_TICKS, PULSE_HI + PULSE_LO),
                                 max2(IDLE_SHORT, IDLE_LONG));
  localparam int CW = $clog2(SPAN_MAX + 1);
  localparam int PW = $clog2(PULSE_COUNT + 1);

  chg_state_t    st;
  logic [CW-1:0] span;
  logic [PW-1:0] pulses;
  logic          span_clr, span_step, pulse_clr, pulse_step;

  chg_ctrl #(
    .TRICKLE_TICKS(TRICKLE_TICKS), .PULSE_HI(PULSE_HI), .PULSE_LO(PULSE_LO),
    .PULSE_COUNT(PULSE_COUNT), .IDLE_SHORT(IDLE_SHORT), .IDLE_LONG(IDLE_LONG),
    .CW(CW), .PW(PW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .bat_present(bat_present), .supply_ok(supply_ok),
    .v_above_dead(v_above_dead), .v_above_trickle(v_above_trickle),
    .v_above_full(v_above_full), .v_above_recharge(v_above_recharge),
    .v_above_droop(v_above_droop), .i_above_term(i_above_term),
    .precheck_en(precheck_en), .idlechk_en(idlechk_en), .idle_long(idle_long),
    .span(span), .pulses(pulses), .st(st),
    .span_clr(span_clr), .span_step(span_step),
    .pulse_clr(pulse_clr), .pulse_step(pulse_step)
  );

  chg_span_cnt #(.W(CW)) u_span (
    .clk(clk), .rst_n(rst_n), .clr(span_clr), .step(span_step), .cnt(span)
  );

  chg_span_cnt #(.W(PW)) u_pulses (
    .clk(clk), .rst_n(rst_n), .clr(pulse_clr), .step(pulse_step), .cnt(pulses)
  );

  chg_led u_led (
    .clk(clk), .rst_n(rst_n), .tick(tick), .st(st), .led0(led0), .led1(led1)
  );

  assign cc_en       = (st == ST_TRICKLE) || (st == ST_CC);
  assign trickle_sel = (st == ST_TRICKLE);
  assign cv_en       = (st == ST_CV);
  assign pulse_drive = (st == ST_PRECHECK) && (span < CW'(PULSE_HI));
endmodule

// File: rtl/chg_seq_chk.sv
module chg_seq_chk
  import chg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       bat_present,
  input logic       cc_en,
  input logic       cv_en,
  input logic       trickle_sel,
  input logic       pulse_drive,
  input logic       led0,
  input logic       led1,
  input chg_state_t st
);
  p_cc_cv_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(cc_en && cv_en));

  p_trickle_in_cc_r12: assert property (@(posedge clk) disable iff (!rst_n)
    trickle_sel |-> cc_en);

  p_removal_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bat_present |=> (st == ST_IDLE));

  p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FAULT && bat_present) |=> (st == ST_FAULT));

  p_fault_blink_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FAULT && bat_present && tick) |=> (led0 != $past(led0)));

  p_fault_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FAULT) |-> (led0 == led1));

  p_pulse_only_probe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_drive |-> (st == ST_PRECHECK && !cc_en && !cv_en));
endmodule

bind chg_seq chg_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bat_present(bat_present),
  .cc_en(cc_en), .cv_en(cv_en), .trickle_sel(trickle_sel),
  .pulse_drive(pulse_drive), .led0(led0), .led1(led1), .st(st)
);

// File: tb/chg_seq_bench.sv
`timescale 1ns/1ps
module chg_seq_bench;
  localparam int TT = 8, PH = 3, PL = 2, PN = 3, IS = 5, IL = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, bat = 0, sup = 0, vdead = 0, vtrk = 0, vfull = 0, vrech = 1;
  logic vdroop = 0, iterm = 1, pre_en = 0, idl_en = 0, idl_long = 0;
  logic cc_en, cv_en, trickle_sel, pulse_drive, led0, led1;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  chg_seq #(.TRICKLE_TICKS(TT), .PULSE_HI(PH), .PULSE_LO(PL), .PULSE_COUNT(PN),
            .IDLE_SHORT(IS), .IDLE_LONG(IL)) u_chg_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bat_present(bat), .supply_ok(sup),
    .v_above_dead(vdead), .v_above_trickle(vtrk), .v_above_full(vfull),
    .v_above_recharge(vrech), .v_above_droop(vdroop), .i_above_term(iterm),
    .precheck_en(pre_en), .idlechk_en(idl_en), .idle_long(idl_long),
    .cc_en(cc_en), .cv_en(cv_en), .trickle_sel(trickle_sel),
    .pulse_drive(pulse_drive), .led0(led0), .led1(led1));

  // bench phases: 0 idle,1 probe high,2 probe low,3 trickle,4 cc,5 cv,6 done/idlechk,7 fault on
  function automatic logic [5:0] want(input int ph);
    case (ph)
      1: return 6'b000110;
      2: return 6'b000010;
      3: return 6'b101010;
      4: return 6'b100010;
      5: return 6'b010010;
      6: return 6'b000001;
      7: return 6'b000011;
      default: return 6'b000000;
    endcase
  endfunction

  task automatic cyc(); @(negedge clk); endtask
  task automatic tk(); tick = 1; @(negedge clk); tick = 0; endtask

  task automatic chk(input string tag, input int ph);
    logic [5:0] got;
    got = {cc_en, cv_en, trickle_sel, pulse_drive, led0, led1};
    checks++;
    if (got !== want(ph)) begin
      errors++;
      $display("FAIL %s got=%b exp=%b", tag, got, want(ph));
    end
  endtask

  task automatic detach();
    bat = 0; sup = 0; cyc(); chk("R8 removal to idle", 0);
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5EED1234);
    repeat (3) cyc();
    rst_n = 1; cyc();
    chk("R1 reset idle", 0);

    // trickle timeout and fault behaviour
    bat = 1; sup = 1; cyc(); chk("R2 start trickle", 3);
    repeat (TT-1) tk();
    chk("R4 trickle before limit", 3);
    tk(); chk("R4 trickle timeout fault", 7);
    tk(); chk("R9 blink off", 0);
    tk(); chk("R9 blink on", 7);
    sup = 0; cyc(); chk("R9 fault ignores supply loss", 7);
    sup = 1; bat = 0; cyc(); chk("R8 removal clears fault", 0);

    // normal path
    iterm = 1; vrech = 1; vfull = 0;
    bat = 1; cyc(); chk("R2 trickle again", 3);
    vtrk = 1; cyc(); chk("R3 trickle to cc", 4);
    vfull = 1; cyc(); chk("R5 cc to cv", 5);
    iterm = 0; cyc(); chk("R6 cv to done", 6);
    repeat (3) tk(); chk("R6 done holds", 6);
    vrech = 0; cyc(); chk("R7 recharge to cc", 4);
    vrech = 1; vfull = 0; sup = 0; cyc(); chk("R8 supply loss to idle", 0);
    sup = 1; cyc(); chk("R2 direct cc", 4);
    detach();

    // pulse probe, dead cell
    pre_en = 1; vdead = 0; vtrk = 0; bat = 1; sup = 1; cyc();
    for (int k = 0; k < (PH+PL)*PN; k++) begin
      chk("R10 probe pulse shape", ((k % (PH+PL)) < PH) ? 1 : 2);
      tk();
    end
    chk("R10 probe dead fault", 7);
    detach();

    // pulse probe, revived cell
    bat = 1; sup = 1; cyc(); chk("R2 probe entry", 1);
    vdead = 1;
    for (int k = 0; k < (PH+PL)*PN - 1; k++) tk();
    chk("R10 probe still running", 2);
    tk(); chk("R10 probe pass to trickle", 3);
    detach();
    pre_en = 0;

    // idle check short, droop fail
    idl_en = 1; idl_long = 0; vtrk = 1; vfull = 1; iterm = 1; vrech = 0; vdroop = 0;
    bat = 1; sup = 1; cyc(); cyc(); chk("R5 reach cv", 5);
    iterm = 0; cyc(); chk("R11 idle check entry", 6);
    repeat (IS-1) tk();
    chk("R11 short check ignores recharge", 6);
    tk(); chk("R11 short droop fault", 7);
    detach();

    // idle check long, pass
    idl_long = 1; vdroop = 1; iterm = 1; vrech = 1;
    bat = 1; sup = 1; cyc(); cyc(); iterm = 0; cyc();
    repeat (IL-1) tk();
    vdroop = 0; cyc(); vdroop = 1;
    chk("R11 long check still running", 6);
    tk(); chk("R11 long pass to done", 6);
    vrech = 0; cyc(); chk("R11 done after pass", 4);
    detach();
    idl_en = 0;

    // random flags through cc/cv/done
    begin
      int ph;
      vtrk = 1; vfull = 0; iterm = 1; vrech = 1; bat = 1; sup = 1; cyc();
      ph = 4; chk("R2 random start", ph);
      for (int i = 0; i < 300; i++) begin
        vfull = 1'($urandom); iterm = 1'($urandom); vrech = 1'($urandom % 4 != 0);
        tick = 1'($urandom);
        cyc(); tick = 0;
        case (ph)
          4: if (vfull) ph = 5;
          5: if (!iterm) ph = 6;
          6: if (!vrech) ph = 4;
          default: ;
        endcase
        chk("R13 R12 random phase", ph);
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule